// File: doc/BRIEF.md
# CSI-2 Receiver Lane Timing Calculator

This block turns a serial link frequency into the four delay-counter settings that a CSI-2 receiver front end needs. These are the termination-enable delay and the settle delay, one pair for the clock lane and one pair shared by every data lane. Each setting is a linear function of the unit interval, counted in sixteenths of a nanosecond. The block evaluates it in 32-bit signed fixed point: the coefficient B is scaled by the counter resolution and by the half-period constant, the result is divided by the frequency after that frequency has been shifted right by eight, and sixteen times the coefficient A is added.

Control logic pulses `calc_start` together with a frequency in hertz. The block checks the shifted frequency. If it lies outside the usable range, the block loads fixed fallback values at once. Otherwise it runs the four settings one after another through a single shared sequential signed divider. In both cases `calc_done` pulses when the results are ready. The results hold until the next accepted run, and `fallback_used` reports which path produced them.

Top module: `csi_lane_timing_calc`

## Requirements
- R1: After reset the four results are 0, `calc_done` is low and `fallback_used` is low.
- R2: For a valid run each result equals 16·A + q, where q is the quotient of 16·B·1953125 (1953125 being 500000000 shifted right by 8) divided by the link frequency arithmetically shifted right by 8.
- R3: The division truncates toward zero, also when the dividend is negative (a quotient of −213.3 gives −213, not −214).
- R4: The coefficient pairs (A, B) are (0, 0) for clock-lane termination, (95, −8) for clock-lane settle, (0, 0) for data-lane termination and (85, −2) for data-lane settle.
- R5: If the shifted frequency is zero or negative, the two termination results take the termination fallback (default 4), the two settle results take the settle fallback (default 128), and `fallback_used` reads 1.
- R6: If the shifted frequency exceeds 2147483647, the same fallback values are loaded and `fallback_used` reads 1.
- R7: A valid run clears `fallback_used` to 0.
- R8: `calc_done` is high for exactly one cycle per accepted run. On a fallback run it is high in the cycle after the start was sampled, and on a valid run it is high within 200 cycles.
- R9: A `calc_start` pulse that arrives while a run is in progress has no effect on that run's results and produces no extra `calc_done`.
- R10: Between runs, with no start, the results and `fallback_used` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calc_start | input | 1 | Single-cycle request to compute; ignored while busy |
| link_freq_hz | input | 64 | Signed link frequency in Hz, sampled with the start |
| clk_term_cnt | output | 32 | Clock-lane termination-enable delay, signed |
| clk_settle_cnt | output | 32 | Clock-lane settle delay, signed |
| dat_term_cnt | output | 32 | Data-lane termination-enable delay, signed |
| dat_settle_cnt | output | 32 | Data-lane settle delay, signed |
| calc_done | output | 1 | One-cycle pulse when results are ready |
| fallback_used | output | 1 | Results came from the fallback values |

## Verification
The bench chooses frequencies whose settle quotients have a fractional part. A divider that floors instead of truncating returns settle values one count too low on those. It drives the range edges directly: frequencies below 256, negative frequencies, a shifted value of exactly 1, a shifted value of exactly 2147483647 and the next one above. Checking the range in the wrong place or at the wrong width shows up as a fallback where a computed value is expected, or the reverse. A second start in the middle of a run is also applied. A design that re-latched the frequency on that start would return values for the wrong frequency, and one that restarted its sequencer would pulse done twice.

// File: rtl/csi_tc_pkg.sv
package csi_tc_pkg;

  localparam int VAL_W    = 32;
  localparam int NUM_VALS = 4;

  typedef logic signed [VAL_W-1:0] val_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FINISH
  } tc_state_e;

  // Dividend of the unit-interval term: inverse resolution * B * (half-period constant >> shift)
  function automatic val_t ui_term_dividend(int acc_inv, int ui_inv, int shift, int coef_b);
    return val_t'(acc_inv * coef_b * (ui_inv >>> shift));
  endfunction

  // Adds the constant term scaled by the counter inverse resolution
  function automatic val_t add_const_term(int acc_inv, int coef_a, val_t quot);
    return quot + val_t'(acc_inv * coef_a);
  endfunction

endpackage

// File: rtl/csi_tc_div.sv
module csi_tc_div
  import csi_tc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  val_t             dividend,
  input  logic [VAL_W-1:0] divisor,
  output logic             busy,
  output logic             q_valid,
  output val_t             quotient
);

  localparam int CNT_W = $clog2(VAL_W + 1);

  logic [VAL_W:0]   rem_q;
  logic [VAL_W-1:0] shq_q;
  logic [VAL_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q;
  logic             run_q;
  logic             fin_q;

  logic [VAL_W-1:0] mag_in;
  logic [VAL_W:0]   trial;
  logic             fits;
  logic             step;

  assign mag_in = dividend[VAL_W-1] ? (~dividend + 1'b1) : dividend;
  assign trial  = {rem_q[VAL_W-1:0], shq_q[VAL_W-1]};
  assign fits   = trial >= {1'b0, den_q};
  assign step   = run_q && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      shq_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      neg_q <= 1'b0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go && !run_q) begin
        rem_q <= '0;
        shq_q <= mag_in;
        den_q <= divisor;
        cnt_q <= CNT_W'(VAL_W);
        neg_q <= dividend[VAL_W-1];
        run_q <= 1'b1;
      end else if (step) begin
        rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
        shq_q <= {shq_q[VAL_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = run_q;
  assign q_valid  = fin_q;
  assign quotient = neg_q ? val_t'(~shq_q + 1'b1) : val_t'(shq_q);

  // R2
  go_nonzero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> divisor != '0);

  // R2
  go_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

  // R3
  trunc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && quotient != '0) |-> quotient[VAL_W-1] == neg_q);

  // R3
  rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> rem_q < {1'b0, den_q});

endmodule

// File: rtl/csi_tc_ctrl.sv
module csi_tc_ctrl
  import csi_tc_pkg::*;
#(
  parameter int FREQ_W     = 64,
  parameter int SHIFT      = 8,
  parameter int ACC_INV    = 16,
  parameter int UI_INV     = 500000000,
  parameter int CT_A       = 0,
  parameter int CT_B       = 0,
  parameter int CS_A       = 95,
  parameter int CS_B       = -8,
  parameter int DT_A       = 0,
  parameter int DT_B       = 0,
  parameter int DS_A       = 85,
  parameter int DS_B       = -2,
  parameter int DEF_TERM   = 4,
  parameter int DEF_SETTLE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [FREQ_W-1:0] link_freq,
  output logic                     div_go,
  output val_t                     div_num,
  output logic [VAL_W-1:0]         div_den,
  input  logic                     div_valid,
  input  val_t                     div_quot,
  output val_t                     res_ct,
  output val_t                     res_cs,
  output val_t                     res_dt,
  output val_t                     res_ds,
  output logic                     done,
  output logic                     used_default,
  output logic                     busy
);

  localparam int IDX_W = $clog2(NUM_VALS);
  localparam logic signed [FREQ_W-1:0] DEN_MAX =
    {{(FREQ_W-VAL_W+1){1'b0}}, {(VAL_W-1){1'b1}}};

  tc_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] den_q;
  logic             dflt_q;
  val_t             res_q [NUM_VALS];

  logic signed [FREQ_W-1:0] freq_sh;
  logic freq_ok;
  logic run_accept;
  logic run_bad;
  logic result_take;
  logic last_take;
  int   cur_a;
  int   cur_b;

  assign freq_sh     = link_freq >>> SHIFT;
  assign freq_ok     = (freq_sh > 0) && (freq_sh <= DEN_MAX);
  assign run_accept  = start && (state_q == ST_IDLE);
  assign run_bad     = run_accept && !freq_ok;
  assign result_take = (state_q == ST_WAIT) && div_valid;
  assign last_take   = result_take && (idx_q == IDX_W'(NUM_VALS - 1));

  always_comb begin
    case (idx_q)
      IDX_W'(0): begin cur_a = CT_A; cur_b = CT_B; end
      IDX_W'(1): begin cur_a = CS_A; cur_b = CS_B; end
      IDX_W'(2): begin cur_a = DT_A; cur_b = DT_B; end
      default:   begin cur_a = DS_A; cur_b = DS_B; end
    endcase
  end

  assign div_go  = (state_q == ST_LAUNCH);
  assign div_num = ui_term_dividend(ACC_INV, UI_INV, SHIFT, cur_b);
  assign div_den = den_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      den_q   <= '0;
      dflt_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (run_accept) begin
            idx_q  <= '0;
            dflt_q <= !freq_ok;
            if (freq_ok) begin
              den_q   <= freq_sh[VAL_W-1:0];
              state_q <= ST_LAUNCH;
            end else begin
              state_q <= ST_FINISH;
            end
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (last_take) begin
            state_q <= ST_FINISH;
          end else if (result_take) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // One result slot per setting; termination slots are even, settle slots odd
  for (genvar g = 0; g < NUM_VALS; g++) begin : g_slot
    localparam int FALLBACK = (g % 2 == 0) ? DEF_TERM : DEF_SETTLE;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[g] <= '0;
      end else if (run_bad) begin
        res_q[g] <= val_t'(FALLBACK);
      end else if (result_take && idx_q == IDX_W'(g)) begin
        res_q[g] <= add_const_term(ACC_INV, cur_a, div_quot);
      end
    end
  end

  assign res_ct       = res_q[0];
  assign res_cs       = res_q[1];
  assign res_dt       = res_q[2];
  assign res_ds       = res_q[3];
  assign done         = (state_q == ST_FINISH);
  assign used_default = dflt_q;
  assign busy         = (state_q != ST_IDLE);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  fallback_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && used_default) |-> (res_ct == val_t'(DEF_TERM) && res_dt == val_t'(DEF_TERM)
                                && res_cs == val_t'(DEF_SETTLE) && res_ds == val_t'(DEF_SETTLE)));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> ($stable(res_ct) && $stable(res_cs) && $stable(res_dt)
                                         && $stable(res_ds) && $stable(used_default)));

  // R9
  busy_den_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q != ST_FINISH) |=> $stable(den_q));

  // R9
  busy_flag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(used_default));

  // R2
  valid_run_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !used_default) |-> den_q != '0);

endmodule

// File: rtl/csi_lane_timing_calc.sv
module csi_lane_timing_calc
  import csi_tc_pkg::*;
#(
  parameter int FREQ_W     = 64,
  parameter int SHIFT      = 8,
  parameter int ACC_INV    = 16,
  parameter int UI_INV     = 500000000,
  parameter int DEF_TERM   = 4,
  parameter int DEF_SETTLE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     calc_start,
  input  logic signed [FREQ_W-1:0] link_freq_hz,
  output logic signed [31:0]       clk_term_cnt,
  output logic signed [31:0]       clk_settle_cnt,
  output logic signed [31:0]       dat_term_cnt,
  output logic signed [31:0]       dat_settle_cnt,
  output logic                     calc_done,
  output logic                     fallback_used
);

  logic             div_go;
  val_t             div_num;
  logic [VAL_W-1:0] div_den;
  logic             div_busy;
  logic             div_valid;
  val_t             div_quot;
  logic             ctrl_busy;

  csi_tc_ctrl #(
    .FREQ_W    (FREQ_W),
    .SHIFT     (SHIFT),
    .ACC_INV   (ACC_INV),
    .UI_INV    (UI_INV),
    .CT_A      (0),
    .CT_B      (0),
    .CS_A      (95),
    .CS_B      (-8),
    .DT_A      (0),
    .DT_B      (0),
    .DS_A      (85),
    .DS_B      (-2),
    .DEF_TERM  (DEF_TERM),
    .DEF_SETTLE(DEF_SETTLE)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (calc_start),
    .link_freq   (link_freq_hz),
    .div_go      (div_go),
    .div_num     (div_num),
    .div_den     (div_den),
    .div_valid   (div_valid),
    .div_quot    (div_quot),
    .res_ct      (clk_term_cnt),
    .res_cs      (clk_settle_cnt),
    .res_dt      (dat_term_cnt),
    .res_ds      (dat_settle_cnt),
    .done        (calc_done),
    .used_default(fallback_used),
    .busy        (ctrl_busy)
  );

  csi_tc_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .dividend(div_num),
    .divisor (div_den),
    .busy    (div_busy),
    .q_valid (div_valid),
    .quotient(div_quot)
  );

  // R8
  div_inside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> ctrl_busy);

endmodule

// File: tb/csi_lane_timing_calc_tb.sv
`timescale 1ns/1ps
module csi_lane_timing_calc_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               calc_start = 1'b0;
  logic signed [63:0] link_freq_hz = '0;
  logic signed [31:0] clk_term_cnt, clk_settle_cnt, dat_term_cnt, dat_settle_cnt;
  logic               calc_done, fallback_used;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  csi_lane_timing_calc u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .calc_start    (calc_start),
    .link_freq_hz  (link_freq_hz),
    .clk_term_cnt  (clk_term_cnt),
    .clk_settle_cnt(clk_settle_cnt),
    .dat_term_cnt  (dat_term_cnt),
    .dat_settle_cnt(dat_settle_cnt),
    .calc_done     (calc_done),
    .fallback_used (fallback_used)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of one setting: 16*A + trunc(16*B*1953125 / (f >>> 8))
  function automatic longint model_val(longint f, longint a, longint b, longint dflt);
    longint sh = f >>> 8;
    if (sh <= 0 || sh > 64'sd2147483647) return dflt;
    return (16 * b * 1953125) / sh + 16 * a;
  endfunction

  function automatic bit model_bad(longint f);
    longint sh = f >>> 8;
    return (sh <= 0 || sh > 64'sd2147483647);
  endfunction

  // Runs one calculation and checks every output against the model
  task automatic run_check(input longint f, input string tag);
    int waitc = 0;
    bit bad = model_bad(f);
    @(negedge clk);
    link_freq_hz = f;
    calc_start   = 1'b1;
    @(negedge clk);
    calc_start   = 1'b0;
    while (!calc_done && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    if (bad) check({tag, " R8 fallback latency"}, waitc, 0);
    else     check({tag, " R8 done within 200"}, (waitc < 200) ? 1 : 0, 1);
    check({tag, " R4 R2 clk term"},   clk_term_cnt,   model_val(f, 0, 0, 4));
    check({tag, " R4 R2 R3 clk settle"}, clk_settle_cnt, model_val(f, 95, -8, 128));
    check({tag, " R4 R2 dat term"},   dat_term_cnt,   model_val(f, 0, 0, 4));
    check({tag, " R4 R2 R3 dat settle"}, dat_settle_cnt, model_val(f, 85, -2, 128));
    check({tag, " R5 R6 R7 flag"}, fallback_used, bad);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, calc_done, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint f;
    longint held_cs;
    int dones;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 clk term", clk_term_cnt, 0);
    check("R1 clk settle", clk_settle_cnt, 0);
    check("R1 dat term", dat_term_cnt, 0);
    check("R1 dat settle", dat_settle_cnt, 0);
    check("R1 done", calc_done, 0);
    check("R1 flag", fallback_used, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners
    run_check(64'sd300000000, "R3 trunc");        // -213.33 -> -213
    run_check(64'sd255, "R5 below");
    run_check(64'sd800000000, "R7 recover");
    run_check(-64'sd1000000, "R5 negative");
    run_check(64'sd256, "R2 shifted one");
    run_check(64'sd511, "R2 shifted one high");
    run_check(64'sh0000_007F_FFFF_FF00, "R6 max ok");
    run_check(64'sh0000_0080_0000_0000, "R6 over");
    run_check(64'sd2000000000, "R3 to zero");
    run_check(64'sd123456789, "R2 odd");

    // R10 hold between runs
    held_cs = clk_settle_cnt;
    repeat (20) @(negedge clk);
    check("R10 hold settle", clk_settle_cnt, held_cs);
    check("R10 hold flag", fallback_used, 0);

    // R9 start while busy: second start carries an invalid frequency
    f = 64'sd450000000;
    @(negedge clk);
    link_freq_hz = f;
    calc_start   = 1'b1;
    @(negedge clk);
    calc_start   = 1'b0;
    repeat (10) @(negedge clk);
    link_freq_hz = 64'sd10;
    calc_start   = 1'b1;
    @(negedge clk);
    calc_start   = 1'b0;
    link_freq_hz = '0;
    dones = 0;
    for (int i = 0; i < 250; i++) begin
      if (calc_done) dones++;
      @(negedge clk);
    end
    check("R9 single done", dones, 1);
    check("R9 clk settle", clk_settle_cnt, model_val(f, 95, -8, 128));
    check("R9 dat settle", dat_settle_cnt, model_val(f, 85, -2, 128));
    check("R9 flag", fallback_used, 0);

    // Constrained random: realistic band, full 64-bit range, near-edge values
    for (int i = 0; i < 60; i++) begin
      case ($urandom_range(0, 2))
        0: f = longint'($urandom_range(32'd50000000, 32'd2500000000));
        1: f = {$urandom, $urandom};
        default: f = longint'($urandom_range(0, 2047));
      endcase
      run_check(f, "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule